// File: doc/BRIEF.md
# Standby-Aware Switcher Mode Selector

This block decides, for each of a small set of switching regulators, which operating mode the converter runs in and which 4-bit output voltage code it is given. Each switcher has two configuration sets, one written by a primary host and one written by a secondary host. Each set holds a mode for normal operation, a mode for standby, a voltage code for normal operation and a voltage code for standby (dynamic voltage scaling).

A per-switcher owner bit hands the switcher to exactly one host. The owner's register set is the only one consulted, and the owner's standby pin is the only pin that matters: primary-owned switchers follow standby pin 1, secondary-owned switchers follow standby pin 2. The two hosts' settings are never combined. Both standby pins are asynchronous to the block and are synchronised before use. The decoded mode and code are registered together, so a converter never sees a new mode paired with an old code. The SPI transport that fills the register sets and the analog converters are outside this block.

Top module: `sw_standby_mode_sel`

## Requirements
- R1: While reset is asserted, every switcher output reads mode 00 (off) and voltage code 0.
- R2: With the owning host's standby pin low, a switcher's mode output equals that host's normal-mode field. The mode encoding is 00 off, 01 synchronous, 10 non-synchronous and 11 low power.
- R3: With the owning host's standby pin high, a switcher's mode output equals that host's standby-mode field.
- R4: When the selected mode is not off, the voltage code is the owner's normal code while its standby pin is low, and the owner's standby code while the pin is high. Low power in the normal state uses the normal code.
- R5: Whenever the mode output is off (00), the voltage code output is 0.
- R6: Owner bit 0 makes a switcher take its fields from the primary set and follow standby pin 1. Owner bit 1 makes it take its fields from the secondary set and follow standby pin 2.
- R7: The non-owner host's fields and the non-owner standby pin have no effect on a switcher's outputs.
- R8: A standby pin change reaches the outputs on the third rising clock edge after it. Mode and code change on the same edge. A field or owner-bit change reaches the outputs on the next edge.
- R9: Each switcher is decoded independently of the others, using its own owner bit and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_pri_i | input | 1 | Standby pin 1 (primary host), asynchronous |
| stby_sec_i | input | 1 | Standby pin 2 (secondary host), asynchronous |
| owner_sec_i | input | NUM_SW | Per-switcher owner: 0 primary, 1 secondary |
| pri_run_mode_i | input | 2*NUM_SW | Primary set, normal-mode fields |
| pri_stby_mode_i | input | 2*NUM_SW | Primary set, standby-mode fields |
| pri_run_vcode_i | input | VCODE_W*NUM_SW | Primary set, normal voltage codes |
| pri_stby_vcode_i | input | VCODE_W*NUM_SW | Primary set, standby voltage codes |
| sec_run_mode_i | input | 2*NUM_SW | Secondary set, normal-mode fields |
| sec_stby_mode_i | input | 2*NUM_SW | Secondary set, standby-mode fields |
| sec_run_vcode_i | input | VCODE_W*NUM_SW | Secondary set, normal voltage codes |
| sec_stby_vcode_i | input | VCODE_W*NUM_SW | Secondary set, standby voltage codes |
| sw_mode_o | output | 2*NUM_SW | Registered mode per switcher |
| sw_vcode_o | output | VCODE_W*NUM_SW | Registered voltage code per switcher |

## Verification
The main sweep covers every owner setting, all four combinations of the two standby pins, and all sixteen pairs of normal and standby modes. The two switchers are given swapped fields and opposite owners, so that a switcher picking the wrong host's set, the wrong pin or its neighbour's data shows up as a mismatch. The non-owner set is always loaded with different values, which tells a correct bank mux from a merged or swapped one. Separate directed steps count the edges from a standby pin change and from a field change to the output, and a further step disturbs only the non-owner pin and set.

// File: rtl/sw_sel_pkg.sv
// Package: shared types for the switcher mode selector.
// Assumes: the mode field is two bits wide with the fixed encoding below.
package sw_sel_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        SWM_OFF     = 2'b00,
        SWM_SYNC    = 2'b01,
        SWM_NONSYNC = 2'b10,
        SWM_LOWPWR  = 2'b11
    } sw_mode_e;

endpackage

// File: rtl/sw_sel_sync.sv
// Module: single-bit multi-stage synchronizer for an asynchronous standby pin.
// Assumes: STAGES >= 2; the input is a slow level, so single-bit sync is enough.
module sw_sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // R8: the output stage copies the previous stage one edge later.
    p_sync_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[STAGES-2] |=> sync_o);
    p_sync_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_q[STAGES-2] |=> !sync_o);

endmodule

// File: rtl/sw_sel_decode.sv
// Module: combinational mode/voltage decode for one switcher.
// Assumes: fields come from the owning host only; stby_i is already synchronised.
module sw_sel_decode
    import sw_sel_pkg::*;
#(
    parameter int VCODE_W = 4
) (
    input  logic [MODE_W-1:0]  run_mode_i,
    input  logic [MODE_W-1:0]  stby_mode_i,
    input  logic [VCODE_W-1:0] run_vcode_i,
    input  logic [VCODE_W-1:0] stby_vcode_i,
    input  logic               stby_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic [VCODE_W-1:0] vcode_o
);

    sw_mode_e sel_mode;

    // Pick the mode field for the current standby state.
    always_comb begin
        sel_mode = sw_mode_e'(stby_i ? stby_mode_i : run_mode_i);
    end

    // Off forces code zero; otherwise take the code for the current state.
    always_comb begin
        case (sel_mode)
            SWM_OFF: vcode_o = '0;
            default: vcode_o = stby_i ? stby_vcode_i : run_vcode_i;
        endcase
    end

    assign mode_o = sel_mode;

endmodule

// File: rtl/sw_sel_lane.sv
// Module: one switcher lane: owner-based bank and pin select, decode, output register.
// Assumes: both standby inputs are synchronised; the owner bit is quasi-static.
module sw_sel_lane
    import sw_sel_pkg::*;
#(
    parameter int VCODE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stby_pri_i,
    input  logic               stby_sec_i,
    input  logic               owner_sec_i,
    input  logic [MODE_W-1:0]  pri_run_mode_i,
    input  logic [MODE_W-1:0]  pri_stby_mode_i,
    input  logic [VCODE_W-1:0] pri_run_vcode_i,
    input  logic [VCODE_W-1:0] pri_stby_vcode_i,
    input  logic [MODE_W-1:0]  sec_run_mode_i,
    input  logic [MODE_W-1:0]  sec_stby_mode_i,
    input  logic [VCODE_W-1:0] sec_run_vcode_i,
    input  logic [VCODE_W-1:0] sec_stby_vcode_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic [VCODE_W-1:0] vcode_o
);

    logic [MODE_W-1:0]  own_run_mode;
    logic [MODE_W-1:0]  own_stby_mode;
    logic [VCODE_W-1:0] own_run_vcode;
    logic [VCODE_W-1:0] own_stby_vcode;
    logic               own_stby;
    logic [MODE_W-1:0]  dec_mode;
    logic [VCODE_W-1:0] dec_vcode;
    logic [MODE_W-1:0]  mode_q;
    logic [VCODE_W-1:0] vcode_q;

    // Exclusive ownership: take the owner's set and the owner's pin, no merging.
    always_comb begin
        if (owner_sec_i) begin
            own_run_mode   = sec_run_mode_i;
            own_stby_mode  = sec_stby_mode_i;
            own_run_vcode  = sec_run_vcode_i;
            own_stby_vcode = sec_stby_vcode_i;
            own_stby       = stby_sec_i;
        end else begin
            own_run_mode   = pri_run_mode_i;
            own_stby_mode  = pri_stby_mode_i;
            own_run_vcode  = pri_run_vcode_i;
            own_stby_vcode = pri_stby_vcode_i;
            own_stby       = stby_pri_i;
        end
    end

    sw_sel_decode #(
        .VCODE_W (VCODE_W)
    ) u_decode (
        .run_mode_i   (own_run_mode),
        .stby_mode_i  (own_stby_mode),
        .run_vcode_i  (own_run_vcode),
        .stby_vcode_i (own_stby_vcode),
        .stby_i       (own_stby),
        .mode_o       (dec_mode),
        .vcode_o      (dec_vcode)
    );

    // Register mode and code together so they always change on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SWM_OFF;
            vcode_q <= '0;
        end else begin
            mode_q  <= dec_mode;
            vcode_q <= dec_vcode;
        end
    end

    assign mode_o  = mode_q;
    assign vcode_o = vcode_q;

    // R2/R6: primary owner, pin 1 low -> primary normal mode on the next edge.
    p_pri_run_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_sec_i && !stby_pri_i) |=> (mode_q == $past(pri_run_mode_i)));
    // R3/R6: secondary owner, pin 2 high -> secondary standby mode.
    p_sec_stby_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_sec_i && stby_sec_i) |=> (mode_q == $past(sec_stby_mode_i)));
    // R4: primary owner, pin 1 low, mode not off -> primary normal code.
    p_pri_run_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_sec_i && !stby_pri_i && (pri_run_mode_i != SWM_OFF))
        |=> (vcode_q == $past(pri_run_vcode_i)));
    // R4: secondary owner, pin 2 high, standby mode not off -> secondary standby code.
    p_sec_stby_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_sec_i && stby_sec_i && (sec_stby_mode_i != SWM_OFF))
        |=> (vcode_q == $past(sec_stby_vcode_i)));
    // R5: an off output always carries code zero.
    p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SWM_OFF) |-> (vcode_q == '0));

endmodule

// File: rtl/sw_standby_mode_sel.sv
// Module: top of the switcher mode selector. Synchronises both standby pins
// once and feeds them to one lane per switcher.
// Assumes: fields arrive flattened, switcher i in slice [i*W +: W].
module sw_standby_mode_sel
    import sw_sel_pkg::*;
#(
    parameter int NUM_SW      = 2,
    parameter int VCODE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stby_pri_i,
    input  logic                      stby_sec_i,
    input  logic [NUM_SW-1:0]         owner_sec_i,
    input  logic [MODE_W*NUM_SW-1:0]  pri_run_mode_i,
    input  logic [MODE_W*NUM_SW-1:0]  pri_stby_mode_i,
    input  logic [VCODE_W*NUM_SW-1:0] pri_run_vcode_i,
    input  logic [VCODE_W*NUM_SW-1:0] pri_stby_vcode_i,
    input  logic [MODE_W*NUM_SW-1:0]  sec_run_mode_i,
    input  logic [MODE_W*NUM_SW-1:0]  sec_stby_mode_i,
    input  logic [VCODE_W*NUM_SW-1:0] sec_run_vcode_i,
    input  logic [VCODE_W*NUM_SW-1:0] sec_stby_vcode_i,
    output logic [MODE_W*NUM_SW-1:0]  sw_mode_o,
    output logic [VCODE_W*NUM_SW-1:0] sw_vcode_o
);

    localparam int NUM_PINS = 2;

    logic [NUM_PINS-1:0] pin_async;
    logic [NUM_PINS-1:0] pin_sync;

    assign pin_async = {stby_sec_i, stby_pri_i};

    // One synchronizer per standby pin, shared by all lanes.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sw_sel_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_async[p]),
            .sync_o  (pin_sync[p])
        );
    end

    // One decode lane per switcher (R9: no cross-lane terms).
    for (genvar i = 0; i < NUM_SW; i++) begin : g_lane
        sw_sel_lane #(
            .VCODE_W (VCODE_W)
        ) u_lane (
            .clk              (clk),
            .rst_n            (rst_n),
            .stby_pri_i       (pin_sync[0]),
            .stby_sec_i       (pin_sync[1]),
            .owner_sec_i      (owner_sec_i[i]),
            .pri_run_mode_i   (pri_run_mode_i[i*MODE_W +: MODE_W]),
            .pri_stby_mode_i  (pri_stby_mode_i[i*MODE_W +: MODE_W]),
            .pri_run_vcode_i  (pri_run_vcode_i[i*VCODE_W +: VCODE_W]),
            .pri_stby_vcode_i (pri_stby_vcode_i[i*VCODE_W +: VCODE_W]),
            .sec_run_mode_i   (sec_run_mode_i[i*MODE_W +: MODE_W]),
            .sec_stby_mode_i  (sec_stby_mode_i[i*MODE_W +: MODE_W]),
            .sec_run_vcode_i  (sec_run_vcode_i[i*VCODE_W +: VCODE_W]),
            .sec_stby_vcode_i (sec_stby_vcode_i[i*VCODE_W +: VCODE_W]),
            .mode_o           (sw_mode_o[i*MODE_W +: MODE_W]),
            .vcode_o          (sw_vcode_o[i*VCODE_W +: VCODE_W])
        );
    end

    // R1: outputs read off and zero on the edge after reset is sampled.
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (sw_mode_o == '0) && (sw_vcode_o == '0));

endmodule

// File: tb/sw_standby_mode_sel_tb.sv
`timescale 1ns/1ps
module sw_standby_mode_sel_tb;

    localparam int N  = 2;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stby_pri, stby_sec;
    logic [N-1:0]  owner;
    logic [2*N-1:0]  p_rm, p_sm, s_rm, s_sm;
    logic [VW*N-1:0] p_rv, p_sv, s_rv, s_sv;
    logic [2*N-1:0]  mode_o;
    logic [VW*N-1:0] vcode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sw_standby_mode_sel #(.NUM_SW(N), .VCODE_W(VW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .stby_pri_i(stby_pri), .stby_sec_i(stby_sec), .owner_sec_i(owner),
        .pri_run_mode_i(p_rm), .pri_stby_mode_i(p_sm),
        .pri_run_vcode_i(p_rv), .pri_stby_vcode_i(p_sv),
        .sec_run_mode_i(s_rm), .sec_stby_mode_i(s_sm),
        .sec_run_vcode_i(s_rv), .sec_stby_vcode_i(s_sv),
        .sw_mode_o(mode_o), .sw_vcode_o(vcode_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load switcher i: owned set gets the given fields, the other set gets distinct ones.
    task automatic set_lane(input int i, input logic own, input logic [1:0] rm,
                            input logic [1:0] sm, input logic [3:0] rv, input logic [3:0] sv);
        logic [1:0] xrm = ~rm;
        logic [1:0] xsm = ~sm;
        owner[i] = own;
        if (!own) begin
            p_rm[i*2 +: 2] = rm;  p_sm[i*2 +: 2] = sm;
            p_rv[i*4 +: 4] = rv;  p_sv[i*4 +: 4] = sv;
            s_rm[i*2 +: 2] = xrm; s_sm[i*2 +: 2] = xsm;
            s_rv[i*4 +: 4] = ~rv; s_sv[i*4 +: 4] = ~sv;
        end else begin
            s_rm[i*2 +: 2] = rm;  s_sm[i*2 +: 2] = sm;
            s_rv[i*4 +: 4] = rv;  s_sv[i*4 +: 4] = sv;
            p_rm[i*2 +: 2] = xrm; p_sm[i*2 +: 2] = xsm;
            p_rv[i*4 +: 4] = ~rv; p_sv[i*4 +: 4] = ~sv;
        end
    endtask

    // Expected outputs for one lane, from the requirements.
    task automatic chk_lane(input string req, input int i, input logic stby,
                            input logic [1:0] rm, input logic [1:0] sm,
                            input logic [3:0] rv, input logic [3:0] sv);
        int em;
        int ev;
        em = stby ? sm : rm;
        ev = (em == 0) ? 0 : (stby ? sv : rv);
        chk(req, mode_o[i*2 +: 2], em);
        chk(req, vcode_o[i*4 +: 4], ev);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        stby_pri = 1'b1; stby_sec = 1'b1;
        owner = '0;
        p_rm = '1; p_sm = '1; s_rm = '1; s_sm = '1;
        p_rv = '1; p_sv = '1; s_rv = '1; s_sv = '1;
        repeat (4) @(negedge clk);
        // R1: outputs off and zero while in reset, despite non-zero fields.
        chk("R1 mode", mode_o, 0);
        chk("R1 vcode", vcode_o, 0);
        stby_pri = 1'b0; stby_sec = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R9: sweep owner, both pins, all mode pairs.
        for (int own = 0; own < 2; own++) begin
            for (int s = 0; s < 4; s++) begin
                for (int rm = 0; rm < 4; rm++) begin
                    for (int sm = 0; sm < 4; sm++) begin
                        logic [3:0] rv0, sv0, rv1, sv1;
                        logic st0, st1;
                        rv0 = 4'({rm[1:0], sm[1:0]}) ^ 4'h5;
                        sv0 = rv0 ^ 4'hA;
                        rv1 = rv0 + 4'd3;
                        sv1 = sv0 + 4'd7;
                        stby_pri = s[0];
                        stby_sec = s[1];
                        set_lane(0, own[0], rm[1:0], sm[1:0], rv0, sv0);
                        set_lane(1, !own[0], sm[1:0], rm[1:0], rv1, sv1);
                        repeat (4) @(negedge clk);
                        st0 = own[0] ? s[1] : s[0];
                        st1 = own[0] ? s[0] : s[1];
                        chk_lane("R2/R3/R4/R5/R6 lane0", 0, st0, rm[1:0], sm[1:0], rv0, sv0);
                        chk_lane("R6/R7/R9 lane1", 1, st1, sm[1:0], rm[1:0], rv1, sv1);
                    end
                end
            end
        end

        // R4: low power in the normal state carries the normal code.
        stby_pri = 1'b0; stby_sec = 1'b0;
        set_lane(0, 1'b0, 2'b11, 2'b01, 4'd6, 4'd12);
        repeat (4) @(negedge clk);
        chk("R4 lowpwr mode", mode_o[1:0], 3);
        chk("R4 lowpwr code", vcode_o[3:0], 6);

        // R7: disturbing only the non-owner pin and set leaves lane 0 unchanged.
        stby_sec = 1'b1;
        s_rm[1:0] = 2'b10; s_sm[1:0] = 2'b00; s_rv[3:0] = 4'd1; s_sv[3:0] = 4'd2;
        repeat (4) @(negedge clk);
        chk("R7 mode", mode_o[1:0], 3);
        chk("R7 code", vcode_o[3:0], 6);

        // R8: pin change appears on the third edge, mode and code together.
        set_lane(0, 1'b0, 2'b01, 2'b10, 4'd5, 4'd9);
        stby_pri = 1'b0;
        repeat (4) @(negedge clk);
        stby_pri = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 mode after 2 edges", mode_o[1:0], 1);
        chk("R8 code after 2 edges", vcode_o[3:0], 5);
        @(negedge clk);
        chk("R8 mode after 3 edges", mode_o[1:0], 2);
        chk("R8 code after 3 edges", vcode_o[3:0], 9);

        // R8: a field change appears one edge later.
        p_sv[3:0] = 4'd14;
        @(negedge clk);
        chk("R8 field latency", vcode_o[3:0], 14);

        // R8: an owner change appears one edge later (lane 0 to secondary, pin 2 high).
        stby_sec = 1'b1;
        repeat (4) @(negedge clk);
        s_rm[1:0] = 2'b00; s_sm[1:0] = 2'b11; s_sv[3:0] = 4'd4;
        owner[0] = 1'b1;
        @(negedge clk);
        chk("R8/R6 owner mode", mode_o[1:0], 3);
        chk("R8/R6 owner code", vcode_o[3:0], 4);

        // R5: standby mode off forces code 0 even with a non-zero standby code.
        s_sm[1:0] = 2'b00;
        @(negedge clk);
        chk("R5 off mode", mode_o[1:0], 0);
        chk("R5 off code", vcode_o[3:0], 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule